// File: doc/BRIEF.md
# Byte-Serial Multi-Precision Adder/Subtractor

This unit adds or subtracts two 32-bit operands using a single 8-bit adder and one carry flag. It works through the operands one byte per clock, starting with the least significant byte, so one adder slice covers the whole word in four steps. The carry produced by each step is passed into the next one. The carry out of the last step is the unsigned overflow indication for an add, or the borrow for a subtract. The unit also provides bytewise AND, OR and XOR, which pass nothing between bytes.

A caller presents both operands, an operation code and a carry-mode select, then pulses the start strobe. The operands are captured into byte registers when the strobe is accepted. The result is assembled one byte per cycle. A one-cycle done pulse marks completion. In chained mode the first step takes the stored flag as its incoming carry (or borrow). This lets several 32-bit operations be strung together into a wider add or subtract.

Top module: `byte_serial_alu`

## Requirements
- R1: After synchronous reset, `result_o`, `carry_o`, `ovf_o` and `done_o` are all zero and the unit is idle, ready to accept a start.
- R2: Op code 0 (add) with `chain_i`=0 yields `result_o` = (A+B) mod 2^32. `done_o` is high in the cycle that follows the fourth rising edge after the edge that accepted the start.
- R3: After an add, `carry_o` equals the carry out of the most significant byte step (1 when A+B, plus any incoming carry, reaches 2^32).
- R4: Op code 1 (subtract) with `chain_i`=0 yields (A-B) mod 2^32. `carry_o` is then the borrow: 1 when A < B taken as unsigned.
- R5: After an add, `ovf_o` is 1 when A and B share bit 31 and the result's bit 31 differs from it. After a subtract, `ovf_o` is 1 when A and B differ in bit 31 and the result's bit 31 differs from A's.
- R6: With `chain_i`=1, the first byte step also takes the stored flag: an add gives A+B+`carry_o`, and a subtract gives A-B-`carry_o`. The flags are then updated exactly as in R3, R4 and R5.
- R7: Op codes 2, 3 and 4 give the bitwise AND, OR and XOR of A and B. They leave `carry_o` and `ovf_o` unchanged.
- R8: Op codes 5, 6 and 7 give a zero result and leave `carry_o` and `ovf_o` unchanged.
- R9: A start strobe that arrives while an operation is in progress (the accepting edge and the four edges after it) is ignored. Its operands and op code have no effect, and it produces no extra done pulse.
- R10: `done_o` is high for exactly one cycle per operation. `result_o`, `carry_o` and `ovf_o` keep their values from the done cycle until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe, sampled only while idle |
| op_i | input | 3 | Operation code (0 add, 1 sub, 2 and, 3 or, 4 xor) |
| chain_i | input | 1 | 1: first step takes the stored carry/borrow flag |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| result_o | output | 32 | Result word |
| done_o | output | 1 | One-cycle completion pulse |
| carry_o | output | 1 | Carry after add, borrow after subtract |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
The bench builds the unit with its default values: an 8-bit digit and four digits. With these values a carry or borrow can ripple through every byte boundary, and directed all-ones and sign-edge operands reach the 2^32 wrap and both signed overflow cases. A randomly driven start strobe also lands in every busy cycle. A behavioural model tracks the expected latency, result and flags, including chained carries taken from earlier operations, and is compared with the outputs on every clock.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4
  } op_e;
endpackage

// File: rtl/bsa_digit_unit.sv
// One digit of the datapath: an adder slice with carry, plus bitwise paths.
module bsa_digit_unit #(
  parameter int DIGIT_W = 8
) (
  input  logic [DIGIT_W-1:0] a_i,
  input  logic [DIGIT_W-1:0] b_i,
  input  logic [2:0]         op_i,
  input  logic               cin_i,
  output logic [DIGIT_W-1:0] y_o,
  output logic [DIGIT_W-1:0] b_eff_o,
  output logic               cout_o
);
  import bsa_pkg::*;

  logic [DIGIT_W:0] sum;

  always_comb begin
    b_eff_o = (op_i == OP_SUB) ? ~b_i : b_i;
    sum     = {1'b0, a_i} + {1'b0, b_eff_o} + {{DIGIT_W{1'b0}}, cin_i};
    cout_o  = sum[DIGIT_W];
    case (op_i)
      OP_ADD, OP_SUB: y_o = sum[DIGIT_W-1:0];
      OP_AND:         y_o = a_i & b_i;
      OP_OR:          y_o = a_i | b_i;
      OP_XOR:         y_o = a_i ^ b_i;
      default:        y_o = '0;
    endcase
  end
endmodule

// File: rtl/bsa_digit_shreg.sv
// Operand storage as digit registers; shifts toward digit 0 on each step.
module bsa_digit_shreg #(
  parameter int DIGIT_W    = 8,
  parameter int NUM_DIGITS = 4,
  localparam int WORD_W    = DIGIT_W * NUM_DIGITS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic               shift_i,
  input  logic [WORD_W-1:0]  word_i,
  output logic [DIGIT_W-1:0] low_o
);
  logic [DIGIT_W-1:0] dig_q [NUM_DIGITS];

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_dig
    if (k == NUM_DIGITS - 1) begin : g_top
      always_ff @(posedge clk) begin
        if (rst)          dig_q[k] <= '0;
        else if (load_i)  dig_q[k] <= word_i[k*DIGIT_W +: DIGIT_W];
        else if (shift_i) dig_q[k] <= '0;
      end
    end else begin : g_mid
      always_ff @(posedge clk) begin
        if (rst)          dig_q[k] <= '0;
        else if (load_i)  dig_q[k] <= word_i[k*DIGIT_W +: DIGIT_W];
        else if (shift_i) dig_q[k] <= dig_q[k+1];
      end
    end
  end

  assign low_o = dig_q[0];
endmodule

// File: rtl/bsa_step_ctrl.sv
// Sequencer: accepts a start while idle, then runs NUM_DIGITS steps.
module bsa_step_ctrl #(
  parameter int NUM_DIGITS = 4,
  localparam int CW = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic accept_o,
  output logic step_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
        end
      end else if (cnt_q == CW'(NUM_DIGITS - 1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign accept_o = start_i && !busy_q;
  assign step_o   = busy_q;
  assign last_o   = busy_q && (cnt_q == CW'(NUM_DIGITS - 1));
  assign busy_o   = busy_q;
  assign done_o   = done_q;
endmodule

// File: rtl/byte_serial_alu.sv
module byte_serial_alu #(
  parameter int DIGIT_W    = 8,
  parameter int NUM_DIGITS = 4,
  localparam int WORD_W    = DIGIT_W * NUM_DIGITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic              chain_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic [WORD_W-1:0] result_o,
  output logic              done_o,
  output logic              carry_o,
  output logic              ovf_o
);
  import bsa_pkg::*;

  logic               accept_w, step_w, last_w, busy_w, done_w;
  logic [DIGIT_W-1:0] a_dig, b_dig, y_dig, b_eff;
  logic               cout_w;
  logic [2:0]         op_q;
  logic               rc_q;
  logic [WORD_W-1:0]  result_q;
  logic               carry_q, ovf_q;
  logic               init_c, is_sub, is_arith;

  bsa_step_ctrl #(.NUM_DIGITS(NUM_DIGITS)) ctrl_i (
    .clk(clk), .rst(rst), .start_i(start_i),
    .accept_o(accept_w), .step_o(step_w), .last_o(last_w),
    .busy_o(busy_w), .done_o(done_w)
  );

  bsa_digit_shreg #(.DIGIT_W(DIGIT_W), .NUM_DIGITS(NUM_DIGITS)) a_reg_i (
    .clk(clk), .rst(rst), .load_i(accept_w), .shift_i(step_w),
    .word_i(a_i), .low_o(a_dig)
  );

  bsa_digit_shreg #(.DIGIT_W(DIGIT_W), .NUM_DIGITS(NUM_DIGITS)) b_reg_i (
    .clk(clk), .rst(rst), .load_i(accept_w), .shift_i(step_w),
    .word_i(b_i), .low_o(b_dig)
  );

  bsa_digit_unit #(.DIGIT_W(DIGIT_W)) unit_i (
    .a_i(a_dig), .b_i(b_dig), .op_i(op_q), .cin_i(rc_q),
    .y_o(y_dig), .b_eff_o(b_eff), .cout_o(cout_w)
  );

  assign is_sub   = (op_q == OP_SUB);
  assign is_arith = (op_q == OP_ADD) || is_sub;

  // Incoming carry of the first step: fixed, or taken from the stored flag.
  always_comb begin
    if (chain_i) init_c = (op_i == OP_SUB) ? ~carry_q : carry_q;
    else         init_c = (op_i == OP_SUB);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q     <= '0;
      rc_q     <= 1'b0;
      result_q <= '0;
      carry_q  <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      if (accept_w) begin
        op_q <= op_i;
        rc_q <= init_c;
      end
      if (step_w) begin
        rc_q     <= cout_w;
        result_q <= {y_dig, result_q[WORD_W-1:DIGIT_W]};
        if (last_w && is_arith) begin
          carry_q <= is_sub ? ~cout_w : cout_w;
          ovf_q   <= (a_dig[DIGIT_W-1] == b_eff[DIGIT_W-1]) &&
                     (y_dig[DIGIT_W-1] != a_dig[DIGIT_W-1]);
        end
      end
    end
  end

  assign result_o = result_q;
  assign done_o   = done_w;
  assign carry_o  = carry_q;
  assign ovf_o    = ovf_q;
endmodule

// File: rtl/bsa_checker.sv
module bsa_checker #(
  parameter int NUM_DIGITS = 4,
  parameter int WORD_W     = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              busy,
  input logic              done_o,
  input logic              carry_o,
  input logic              ovf_o,
  input logic [WORD_W-1:0] result_o
);
  localparam int CW = $clog2(NUM_DIGITS + 2);
  logic [CW-1:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (rst)                    lat_cnt <= '0;
    else if (start_i && !busy)  lat_cnt <= '0;
    else if (busy)              lat_cnt <= lat_cnt + 1'b1;
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (result_o == '0 && !carry_o && !ovf_o && !done_o && !busy));

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (lat_cnt == CW'(NUM_DIGITS)));

  p_carry_at_done_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(carry_o) |-> done_o);

  p_ovf_at_done_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(ovf_o) |-> done_o);

  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start_i) |=> ($stable(result_o) && $stable(carry_o) && $stable(ovf_o)));
endmodule

bind byte_serial_alu bsa_checker #(.NUM_DIGITS(NUM_DIGITS), .WORD_W(WORD_W)) chk_i (
  .clk(clk), .rst(rst), .start_i(start_i), .busy(busy_w), .done_o(done_o),
  .carry_o(carry_o), .ovf_o(ovf_o), .result_o(result_o)
);

// File: tb/byte_serial_alu_tb_top.sv
module byte_serial_alu_tb_top;
  localparam int DW = 8;
  localparam int ND = 4;
  localparam int WW = DW * ND;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          chain = 1'b0;
  logic [2:0]    op = 3'd0;
  logic [WW-1:0] a = '0, b = '0;
  logic [WW-1:0] result_o;
  logic          done_o, carry_o, ovf_o;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  byte_serial_alu #(.DIGIT_W(DW), .NUM_DIGITS(ND)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .op_i(op), .chain_i(chain),
    .a_i(a), .b_i(b), .result_o(result_o), .done_o(done_o),
    .carry_o(carry_o), .ovf_o(ovf_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int            m_cnt = 0;
  bit            m_done = 0, m_c = 0, m_v = 0;
  logic [WW-1:0] m_res = '0, p_res = '0;
  bit            p_c = 0, p_v = 0, p_chain = 0;
  logic [2:0]    p_op = 3'd0;

  always @(posedge clk) begin : model
    logic [WW:0] s;
    if (rst) begin
      m_cnt <= 0; m_done <= 0; m_c <= 0; m_v <= 0; m_res <= '0;
    end else begin
      m_done <= 0;
      if (m_cnt != 0) begin
        if (m_cnt == ND) begin
          m_cnt <= 0; m_done <= 1; m_res <= p_res; m_c <= p_c; m_v <= p_v;
        end else m_cnt <= m_cnt + 1;
      end else if (start) begin
        m_cnt <= 1; p_op <= op; p_chain <= chain;
        p_c <= m_c; p_v <= m_v;
        case (op)
          3'd0: begin
            s = {1'b0, a} + {1'b0, b} + (WW+1)'(chain ? m_c : 1'b0);
            p_res <= s[WW-1:0]; p_c <= s[WW];
            p_v <= (a[WW-1] == b[WW-1]) && (s[WW-1] != a[WW-1]);
          end
          3'd1: begin
            s = {1'b0, a} - {1'b0, b} - (WW+1)'(chain ? m_c : 1'b0);
            p_res <= s[WW-1:0]; p_c <= s[WW];
            p_v <= (a[WW-1] != b[WW-1]) && (s[WW-1] != a[WW-1]);
          end
          3'd2: p_res <= a & b;
          3'd3: p_res <= a | b;
          3'd4: p_res <= a ^ b;
          default: p_res <= '0;
        endcase
      end
    end
  end

  function automatic string res_tag(input logic [2:0] o, input bit ch);
    if (o <= 3'd1 && ch) return "R6 result";
    if (o == 3'd0) return "R2 result";
    if (o == 3'd1) return "R4 result";
    if (o <= 3'd4) return "R7 result";
    return "R8 result";
  endfunction

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(done_o == m_done, "R10 done pulse", 64'(done_o), 64'(m_done));
      if (m_cnt == 0)
        chk(result_o == m_res, res_tag(p_op, p_chain), 64'(result_o), 64'(m_res));
      chk(carry_o == m_c, (p_op <= 3'd1) ? (p_chain ? "R6 flag" : "R3 carry/borrow") : "R7 carry kept",
          64'(carry_o), 64'(m_c));
      chk(ovf_o == m_v, (p_op <= 3'd1) ? "R5 overflow" : "R7 overflow kept", 64'(ovf_o), 64'(m_v));
    end
  end

  task automatic run_op(input logic [2:0] o, input logic [WW-1:0] x, input logic [WW-1:0] y, input bit ch);
    @(negedge clk);
    op = o; a = x; b = y; chain = ch; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (ND) @(negedge clk);
    chk(done_o == 1'b1, "R2 latency", 64'(done_o), 64'd1);
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(result_o == '0 && !carry_o && !ovf_o && !done_o, "R1 reset state",
        {carry_o, ovf_o, done_o, result_o}, 64'd0);

    run_op(3'd0, 32'h1234_5678, 32'h0101_0101, 0);
    chk(result_o == 32'h1335_5779, "R2 sum", 64'(result_o), 64'h1335_5779);
    run_op(3'd0, 32'hFFFF_FFFF, 32'h1, 0);
    chk(result_o == 0 && carry_o, "R3 wrap carry", {carry_o, result_o}, 64'h1_0000_0000);
    run_op(3'd0, 32'h7FFF_FFFF, 32'h1, 0);
    chk(ovf_o && !carry_o, "R5 add overflow", {carry_o, ovf_o}, 64'd1);
    run_op(3'd1, 32'h0, 32'h1, 0);
    chk(result_o == 32'hFFFF_FFFF && carry_o, "R4 borrow", {carry_o, result_o}, 64'h1_FFFF_FFFF);
    run_op(3'd1, 32'h8000_0000, 32'h1, 0);
    chk(result_o == 32'h7FFF_FFFF && ovf_o && !carry_o, "R5 sub overflow",
        {carry_o, ovf_o, result_o}, 64'h1_7FFF_FFFF);

    run_op(3'd0, 32'hFFFF_FFFF, 32'h1, 0);
    run_op(3'd0, 32'h5, 32'h6, 1);
    chk(result_o == 32'hC && !carry_o, "R6 chained carry in", {carry_o, result_o}, 64'hC);
    run_op(3'd0, 32'h5, 32'h6, 1);
    chk(result_o == 32'hB, "R6 cleared flag", 64'(result_o), 64'hB);
    run_op(3'd1, 32'h0, 32'h1, 0);
    run_op(3'd1, 32'h10, 32'h1, 1);
    chk(result_o == 32'hE, "R6 chained borrow", 64'(result_o), 64'hE);

    run_op(3'd0, 32'h8000_0000, 32'h8000_0000, 0);
    run_op(3'd2, 32'hF0F0_F0F0, 32'hFF00_FF00, 0);
    chk(result_o == 32'hF000_F000 && carry_o && ovf_o, "R7 and, flags kept",
        {carry_o, ovf_o, result_o}, 64'h3_F000_F000);
    run_op(3'd3, 32'hF0F0_F0F0, 32'h0F00_000F, 0);
    chk(result_o == 32'hFFF0_F0FF, "R7 or", 64'(result_o), 64'hFFF0_F0FF);
    run_op(3'd4, 32'hFFFF_0000, 32'hFF00_FF00, 0);
    chk(result_o == 32'h00FF_FF00 && carry_o && ovf_o, "R7 xor, flags kept",
        {carry_o, ovf_o, result_o}, 64'h3_00FF_FF00);
    run_op(3'd6, 32'h1234, 32'h5678, 0);
    chk(result_o == 0 && carry_o && ovf_o, "R8 reserved op", {carry_o, ovf_o, result_o}, 64'h3_0000_0000);

    // R9: start held high through the busy cycles with other operands
    @(negedge clk);
    op = 3'd0; a = 32'h1; b = 32'h2; chain = 0; start = 1'b1;
    @(negedge clk);
    op = 3'd1; a = 32'h100; b = 32'h1;
    repeat (ND) @(negedge clk);
    chk(done_o == 1'b1 && result_o == 32'h3, "R9 busy start ignored", 64'(result_o), 64'h3);
    start = 1'b0;
    repeat (ND + 1) begin
      @(negedge clk);
      chk(done_o == 1'b0, "R9 no extra done", 64'(done_o), 64'd0);
    end

    // R10: outputs hold while idle
    repeat (6) begin
      @(negedge clk);
      chk(result_o == 32'h3, "R10 result held", 64'(result_o), 64'h3);
    end

    // Random traffic; the per-clock model compare checks every cycle
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      start = ($urandom_range(0, 2) == 0);
      op    = 3'($urandom_range(0, 7));
      chain = 1'($urandom_range(0, 1));
      a     = ($urandom_range(0, 4) == 0) ? 32'hFFFF_FFFF : $urandom;
      b     = ($urandom_range(0, 4) == 0) ? 32'h8000_0000 : $urandom;
    end
    @(negedge clk);
    start = 1'b0;
    repeat (ND + 3) @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule